// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This controller decides, cycle by cycle, which peripheral clock branches run and whether the CPU clock is held. Software programs three things over a simple write-only register bus: a clock-mode register, a peripheral enable register and an idle-select bit. From these the block derives one of three operating modes: normal active, low-power active or low-power idle. It drives a registered gate enable for each peripheral and a CPU halt output. The gate cells are modelled as enable signals only.

Peripherals that can demand their own clock raise a request line. A raised request forces that gate on, whatever the mode. CPU accesses to peripheral registers pass through the block. An access aimed at a peripheral whose clock is gated is not forwarded, and it raises an error flag instead.

A wake pulse ends idle. It clears the idle-select bit and releases the halt. The clock mode is left as it was, so the chip returns to low-power active mode.

Top module: `lpcg_ctrl`

## Requirements
- R1: After reset all gate enables are 1, the halt output is 0 and the error flag is 0.
- R2: With low-power mode not armed, every gate enable is 1 for any enable register value.
- R3: Low-power mode is armed exactly when a write to the mode register (address 0) sets both bit 1 and bit 2. Any write that leaves either bit clear, including 0x00, disarms it.
- R4: In low-power active mode, gate g follows bit 4 + g/2 of the enable register (address 1). The halt output stays 0.
- R5: In low-power idle mode, gate g follows bit g/2 of the enable register, and the halt output is 1.
- R6: A write of 1 to bit 0 of the idle register (address 2) selects idle only while low-power mode is armed. Otherwise the write is ignored.
- R7: While clock request g is high, gate enable g is 1 from the next clock edge, in every mode.
- R8: An access to a peripheral whose gate is 0 is not forwarded, and the error flag is 1 in the following cycle. An access to a running peripheral is forwarded as a one-hot strobe, and the error flag stays 0.
- R9: A wake pulse clears the idle selection and releases the halt. The mode register keeps its value.
- R10: Disarming low-power mode also clears the idle selection. Re-arming later therefore does not halt the CPU.
- R11: Gate and halt outputs are registered. They change on the clock edge after the register write, or after the request edge, that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 mode, 1 enable, 2 idle |
| bus_wdata_i | input | 8 | Write data |
| wake_i | input | 1 | Enabled interrupt or wake pulse |
| clk_req_i | input | 8 | Per-peripheral clock requests |
| per_acc_i | input | 1 | CPU peripheral access strobe |
| per_sel_i | input | 3 | Target peripheral index |
| gate_en_o | output | 8 | Registered gate enables |
| cpu_halt_o | output | 1 | CPU clock halt |
| per_acc_o | output | 8 | Forwarded one-hot access strobe |
| per_err_o | output | 1 | Gated-access error flag |

## Verification
The hardest state to reach from the ports is idle with a clock request competing against the idle nibble. The bench gets there by arming the mode, then selecting idle, then sweeping all request patterns against a fixed enable value. A second hard state is a disarm that must also clear a pending idle selection. The bench reaches it by disarming from idle and then re-arming, and it checks that the halt stays low.

// File: rtl/lpcg_pkg.sv
package lpcg_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] ADDR_MODE = 2'd0;
  localparam logic [AW-1:0] ADDR_EN   = 2'd1;
  localparam logic [AW-1:0] ADDR_IDLE = 2'd2;
  localparam int ARM_BIT_A = 1;
  localparam int ARM_BIT_B = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_LP_ACT  = 2'd1,
    MODE_LP_IDLE = 2'd2
  } lp_mode_e;
endpackage

// File: rtl/lpcg_regs.sv
module lpcg_regs
  import lpcg_pkg::*;
#(
  parameter int EN_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wake_i,
  output logic            armed_o,
  output logic            idle_o,
  output logic [EN_W-1:0] en_o
);
  logic [1:0]      arm_q;
  logic            idle_q;
  logic [EN_W-1:0] en_q;

  logic wr_mode, wr_en, wr_idle, mode_arms;
  assign wr_mode   = we_i && (addr_i == ADDR_MODE);
  assign wr_en     = we_i && (addr_i == ADDR_EN);
  assign wr_idle   = we_i && (addr_i == ADDR_IDLE);
  assign mode_arms = wdata_i[ARM_BIT_A] & wdata_i[ARM_BIT_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      en_q   <= '0;
      idle_q <= 1'b0;
    end else begin
      if (wr_mode) arm_q <= {wdata_i[ARM_BIT_B], wdata_i[ARM_BIT_A]};
      if (wr_en)   en_q  <= wdata_i[EN_W-1:0];
      if (wake_i)                     idle_q <= 1'b0;
      else if (wr_mode && !mode_arms) idle_q <= 1'b0;
      else if (wr_idle && armed_o)    idle_q <= wdata_i[0];
    end
  end

  assign armed_o = &arm_q;
  assign idle_o  = idle_q;
  assign en_o    = en_q;

  a_r9_wake_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !idle_q);
  a_r9_wake_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !we_i) |=> $stable(arm_q));
  a_r10_idle_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q |-> armed_o);
  a_r6_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idle && !armed_o) |=> !idle_q);
endmodule

// File: rtl/lpcg_gate_calc.sv
module lpcg_gate_calc
  import lpcg_pkg::*;
#(
  parameter int N_GATES = 8,
  parameter int N_BR    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               armed_i,
  input  logic               idle_i,
  input  logic [2*N_BR-1:0]  en_i,
  input  logic [N_GATES-1:0] req_i,
  output logic [N_GATES-1:0] gate_o,
  output logic               halt_o
);
  localparam int PER_BR = N_GATES / N_BR;

  lp_mode_e               mode;
  logic [N_GATES-1:0]     gate_d, gate_q;
  logic                   halt_q;

  always_comb begin
    if (!armed_i)    mode = MODE_NORMAL;
    else if (idle_i) mode = MODE_LP_IDLE;
    else             mode = MODE_LP_ACT;
  end

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    localparam int BR = g / PER_BR;
    logic sel_en;
    always_comb begin
      unique case (mode)
        MODE_LP_ACT:  sel_en = en_i[N_BR + BR];
        MODE_LP_IDLE: sel_en = en_i[BR];
        default:      sel_en = 1'b1;
      endcase
    end
    assign gate_d[g] = sel_en | req_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '1;
      halt_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      halt_q <= (mode == MODE_LP_IDLE);
    end
  end

  assign gate_o = gate_q;
  assign halt_o = halt_q;

  a_r2_normal_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (gate_q == '1));
  a_r7_req_forces_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((gate_q & $past(req_i)) == $past(req_i)));
  a_r5_halt_only_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> $past(armed_i && idle_i));
endmodule

// File: rtl/lpcg_acc_chk.sv
module lpcg_acc_chk #(
  parameter int N_GATES = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_GATES-1:0] gate_i,
  input  logic               acc_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [N_GATES-1:0] acc_o,
  output logic               err_o
);
  logic tgt_on;
  logic err_q;

  assign tgt_on = gate_i[sel_i];

  always_comb begin
    acc_o = '0;
    if (acc_i && tgt_on) acc_o[sel_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= acc_i && !tgt_on;
  end

  assign err_o = err_q;

  a_r8_onehot_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_o));
  a_r8_gated_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !tgt_on) |=> err_o);
  a_r8_err_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != '0) |=> !err_o);
endmodule

// File: rtl/lpcg_ctrl.sv
module lpcg_ctrl
  import lpcg_pkg::*;
#(
  parameter int N_GATES = 8,
  parameter int N_BR    = 4,
  parameter int SEL_W   = $clog2(N_GATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic               wake_i,
  input  logic [N_GATES-1:0] clk_req_i,
  input  logic               per_acc_i,
  input  logic [SEL_W-1:0]   per_sel_i,
  output logic [N_GATES-1:0] gate_en_o,
  output logic               cpu_halt_o,
  output logic [N_GATES-1:0] per_acc_o,
  output logic               per_err_o
);
  localparam int EN_W = 2 * N_BR;

  logic            armed, idle;
  logic [EN_W-1:0] en;

  lpcg_regs #(.EN_W(EN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .wake_i  (wake_i),
    .armed_o (armed),
    .idle_o  (idle),
    .en_o    (en)
  );

  lpcg_gate_calc #(.N_GATES(N_GATES), .N_BR(N_BR)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed),
    .idle_i  (idle),
    .en_i    (en),
    .req_i   (clk_req_i),
    .gate_o  (gate_en_o),
    .halt_o  (cpu_halt_o)
  );

  lpcg_acc_chk #(.N_GATES(N_GATES), .SEL_W(SEL_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_en_o),
    .acc_i  (per_acc_i),
    .sel_i  (per_sel_i),
    .acc_o  (per_acc_o),
    .err_o  (per_err_o)
  );

  a_r11_gate_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(gate_en_o) || $past(bus_we_i) || $past(clk_req_i) != $past(clk_req_i, 2)
    || $past(wake_i) || $past(armed) != $past(armed, 2) || $past(idle) != $past(idle, 2)
    || $past(en) != $past(en, 2) || $past(clk_req_i) != '0);
endmodule

// File: tb/lpcg_ctrl_tb.sv
module lpcg_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wake = 1'b0;
  logic [7:0] req = '0;
  logic       acc = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] gate, fwd;
  logic       halt, err;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lpcg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .wake_i(wake), .clk_req_i(req), .per_acc_i(acc),
    .per_sel_i(sel), .gate_en_o(gate), .cpu_halt_o(halt), .per_acc_o(fwd),
    .per_err_o(err)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // gate g follows bit 4+g/2 (active) or g/2 (idle); all on when not armed
  function automatic logic [7:0] exp_gate(input logic arm, input logic idl,
                                          input logic [7:0] en, input logic [7:0] rq);
    logic [7:0] e;
    for (int g = 0; g < 8; g++) begin
      if (!arm)     e[g] = 1'b1;
      else if (idl) e[g] = en[g/2];
      else          e[g] = en[4 + g/2];
    end
    return e | rq;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gates", gate, 8'hFF);
    chk("R1 halt", halt, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    settle();

    // R2: normal mode ignores enable register
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, v[7:0]); settle();
      chk("R2 normal all on", gate, 8'hFF);
    end

    // R3: arming sweep over all mode values
    wr(2'd1, 8'h00);
    for (int m = 0; m < 256; m++) begin
      logic a;
      a = m[1] & m[2];
      wr(2'd0, m[7:0]); settle();
      chk("R3 arm decode", gate, exp_gate(a, 1'b0, 8'h00, 8'h00));
      wr(2'd0, 8'h00); settle();
      chk("R3 disarm by 0x00", gate, 8'hFF);
    end

    // R4 + R11: active mode sweep
    wr(2'd0, 8'h06); settle();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = gate;
      wr(2'd1, v[7:0]);
      chk("R11 not before edge", gate, prev);
      settle();
      chk("R4 active nibble", gate, exp_gate(1'b1, 1'b0, v[7:0], 8'h00));
      chk("R4 no halt", halt, 0);
    end

    // R5: idle sweep
    wr(2'd2, 8'h01);
    chk("R11 halt not before edge", halt, 0);
    settle();
    chk("R5 halt", halt, 1);
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, v[7:0]); settle();
      chk("R5 idle nibble", gate, exp_gate(1'b1, 1'b1, v[7:0], 8'h00));
    end

    // R7: requests in idle against a fixed enable
    wr(2'd1, 8'h5A); settle();
    for (int r = 0; r < 256; r++) begin
      @(negedge clk); req = r[7:0];
      chk("R11 req not before edge", gate, exp_gate(1'b1, 1'b1, 8'h5A, 8'h00));
      @(negedge clk);
      chk("R7 req override idle", gate, exp_gate(1'b1, 1'b1, 8'h5A, r[7:0]));
      req = 8'h00;
      @(negedge clk);
      chk("R7 req release", gate, exp_gate(1'b1, 1'b1, 8'h5A, 8'h00));
    end

    // R9: wake clears idle, mode kept
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    settle();
    chk("R9 halt released", halt, 0);
    chk("R9 mode kept", gate, exp_gate(1'b1, 1'b0, 8'h5A, 8'h00));

    // R7 in active mode
    @(negedge clk); req = 8'hFF;
    @(negedge clk);
    chk("R7 req override active", gate, 8'hFF);
    req = 8'h00; settle();

    // R10: disarm from idle clears idle selection
    wr(2'd2, 8'h01); settle();
    chk("R10 precondition halt", halt, 1);
    wr(2'd0, 8'h00); settle();
    chk("R10 halt off", halt, 0);
    chk("R10 gates on", gate, 8'hFF);
    wr(2'd0, 8'h06); settle();
    chk("R10 rearm no halt", halt, 0);

    // R6: idle write while not armed is ignored
    wr(2'd0, 8'h02); settle();
    wr(2'd2, 8'h01); settle();
    chk("R6 ignored halt", halt, 0);
    wr(2'd0, 8'h06); settle();
    chk("R6 no idle after arm", halt, 0);
    chk("R6 active gates", gate, exp_gate(1'b1, 1'b0, 8'h5A, 8'h00));

    // R8: gated access in active mode, enable 0x50 -> gates 0,1,4,5
    wr(2'd1, 8'h50); settle();
    for (int s = 0; s < 8; s++) begin
      logic on;
      on = (s == 0) || (s == 1) || (s == 4) || (s == 5);
      @(negedge clk); acc = 1'b1; sel = s[2:0];
      #1;
      chk("R8 forward", fwd, on ? (8'h01 << s) : 8'h00);
      @(negedge clk); acc = 1'b0;
      chk("R8 err", err, !on);
      @(negedge clk);
      chk("R8 err clears", err, 0);
    end
    wr(2'd0, 8'h00); settle();
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); acc = 1'b1; sel = s[2:0];
      #1;
      chk("R8 normal forward", fwd, 8'h01 << s);
      @(negedge clk); acc = 1'b0;
      chk("R8 normal no err", err, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule